// File: doc/BRIEF.md
# Indexed-Colour Display Register File

This block is the processor-facing register file of an indexed-colour display controller. A processor reaches it through a simple synchronous access port carrying a byte address, a size code, write data and a combinational read-data return. The block holds the visible geometry (width and height), a control word, the frame start address, the cursor position, a 256-entry colour lookup table, a 3-entry cursor colour table and a 512-entry cursor bitmap. It presents the decoded values to the pixel and timing logic as plain outputs.

Geometry is kept in pixels but programmed in scaled units, so software sees one unit per four pixels horizontally and one unit per half line vertically. Accesses of 8, 16 and 32 bits are all accepted. A narrow write is formed by merging the new bytes into the current readback value of the addressed word, so that write-only locations merge with zero. A refresh-done pulse from the pixel pipeline raises an interrupt, and any register write drops it again. Writes to unmapped addresses outside a reserved timing range raise a one-cycle error pulse.

Top module: `disp_ctrl_regs`

## Requirements
- R1: The word at byte address 0x000 reads 0x00000010; writes to it change nothing and raise no error pulse.
- R2: A write of v to the horizontal register (0x008) sets width_px to v*4 (truncated to DIM_W bits); reading 0x008 returns width_px/4.
- R3: A write of v to the vertical register (0x010) sets height_px to v/2; reading 0x010 returns height_px*2, so an odd v reads back as v-1.
- R4: The control word at 0x018 is stored in full and read back; its bits 22:20 give pixel_depth through the table 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6→0, 7→0; bit 10 drives force_blank and bit 23 drives cursor_off.
- R5: Table entries sit every 8 bytes and both words of a slot address the same entry (index = (address − base) >> 3). Colour table: base 0x800, 256 entries, RGB in bits 23:0, visible on lut_rgb for lut_index and read as zero. Cursor colour table: base 0x100, 3 entries, 24 bits, readable. Cursor bitmap: base 0x1000, 512 entries of 16 bits, readable.
- R6: Size code 0 is a byte, 1 a halfword, 2 or 3 a word. A halfword read returns bits 31:16 when address bit 1 is set and bits 15:0 otherwise; a byte read returns lane (address mod 4); results are zero-extended.
- R7: A byte or halfword write replaces only its lane of the addressed word's current readback value; locations that read as zero (frame start, cursor position, colour table) therefore merge with zero.
- R8: The frame start word (0x020) drives top_addr; the cursor position word (0x028) drives cursor_x from bits 23:12 and cursor_y from bits 11:0; both read as zero.
- R9: Writes to word addresses 0x040 to 0x07C are accepted and ignored without an error pulse; reads of any unmapped address return zero.
- R10: A write to any other unmapped address sets bad_write for exactly the following cycle.
- R11: refresh_done raises irq in the next cycle; any write lowers irq in the next cycle and wins over a simultaneous refresh_done.
- R12: A write to 0x030, like rst_n, clears every register and table entry to zero and lowers irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_wdata | input | 32 | Write data, low-aligned for narrow writes |
| acc_rdata | output | 32 | Read data for acc_addr and acc_size |
| refresh_done | input | 1 | One-cycle pulse at end of a display refresh |
| lut_index | input | log2(PAL_ENTRIES) | Colour table lookup index |
| lut_rgb | output | 24 | Colour table entry at lut_index |
| width_px | output | DIM_W | Display width in pixels |
| height_px | output | DIM_W | Display height in lines |
| pixel_depth | output | 5 | Bits per pixel decoded from control |
| force_blank | output | 1 | Control bit 10 |
| cursor_off | output | 1 | Control bit 23 |
| top_addr | output | 32 | Frame start address |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| irq | output | 1 | Refresh interrupt |
| bad_write | output | 1 | Unmapped-write pulse |

## Verification
The hardest state to reach is a narrow write landing on a location whose readback differs from its stored value, because the merge then depends on the read path rather than on storage. The bench writes single bytes to the frame start word and to a colour table slot, then reads the results through top_addr and lut_rgb, where the untouched lanes must come out zero. The race between a write and refresh_done in the same cycle is forced by driving both strobes at one falling edge.

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs #(
  parameter int ADDR_W       = 13,
  parameter int DIM_W        = 12,
  parameter int PAL_ENTRIES  = 256,
  parameter int CPAT_ENTRIES = 512,
  parameter int CPAL_BASE    = 'h100,
  parameter int CLR_BASE     = 'h800,
  parameter int CPAT_BASE    = 'h1000,
  localparam int PAL_IW      = $clog2(PAL_ENTRIES),
  localparam int CPAT_IW     = $clog2(CPAT_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              refresh_done,
  input  logic [PAL_IW-1:0] lut_index,
  output logic [23:0]       lut_rgb,
  output logic [DIM_W-1:0]  width_px,
  output logic [DIM_W-1:0]  height_px,
  output logic [4:0]        pixel_depth,
  output logic              force_blank,
  output logic              cursor_off,
  output logic [31:0]       top_addr,
  output logic [11:0]       cursor_x,
  output logic [11:0]       cursor_y,
  output logic              irq,
  output logic              bad_write
);

  localparam int CPAL_N = 3;
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_HD   = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] A_VD   = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'('h018);
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] A_CPOS = ADDR_W'('h028);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'('h030);
  localparam logic [ADDR_W:0] IGN_LO   = (ADDR_W+1)'('h040);
  localparam logic [ADDR_W:0] IGN_HI   = (ADDR_W+1)'('h080);
  localparam logic [ADDR_W:0] CPAL_LO  = (ADDR_W+1)'(CPAL_BASE);
  localparam logic [ADDR_W:0] CPAL_HI  = (ADDR_W+1)'(CPAL_BASE + CPAL_N*8);
  localparam logic [ADDR_W:0] CLR_LO   = (ADDR_W+1)'(CLR_BASE);
  localparam logic [ADDR_W:0] CLR_HI   = (ADDR_W+1)'(CLR_BASE + PAL_ENTRIES*8);
  localparam logic [ADDR_W:0] CPAT_LO  = (ADDR_W+1)'(CPAT_BASE);
  localparam logic [ADDR_W:0] CPAT_HI  = (ADDR_W+1)'(CPAT_BASE + CPAT_ENTRIES*8);

  logic [23:0] clr_q  [PAL_ENTRIES];
  logic [23:0] cpal_q [CPAL_N];
  logic [15:0] cpat_q [CPAT_ENTRIES];
  logic [31:0] ctrl_q, top_q;
  logic [23:0] cpos_q;

  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W:0]   wa_x;
  logic              wr_now, in_cpal, in_clr, in_cpat, in_ign, is_reg, clr_all;
  logic [ADDR_W-1:0] cpal_off, clr_off, cpat_off;
  logic [1:0]        cpal_idx;
  logic [PAL_IW-1:0] clr_idx;
  logic [CPAT_IW-1:0] cpat_idx;
  logic [31:0]       cur_word, new_word;

  assign waddr    = {acc_addr[ADDR_W-1:2], 2'b00};
  assign wa_x     = {1'b0, waddr};
  assign wr_now   = acc_en && acc_wr;
  assign in_cpal  = wa_x >= CPAL_LO && wa_x < CPAL_HI;
  assign in_clr   = wa_x >= CLR_LO  && wa_x < CLR_HI;
  assign in_cpat  = wa_x >= CPAT_LO && wa_x < CPAT_HI;
  assign in_ign   = wa_x >= IGN_LO  && wa_x < IGN_HI;
  assign is_reg   = waddr inside {A_ID, A_HD, A_VD, A_CTL, A_TOP, A_CPOS, A_RST};
  assign clr_all  = wr_now && waddr == A_RST;
  assign cpal_off = waddr - ADDR_W'(CPAL_BASE);
  assign clr_off  = waddr - ADDR_W'(CLR_BASE);
  assign cpat_off = waddr - ADDR_W'(CPAT_BASE);
  assign cpal_idx = 2'(cpal_off >> 3);
  assign clr_idx  = PAL_IW'(clr_off >> 3);
  assign cpat_idx = CPAT_IW'(cpat_off >> 3);

  always_comb begin
    cur_word = '0;
    if (in_cpat)      cur_word = {16'h0, cpat_q[cpat_idx]};
    else if (in_cpal) cur_word = {8'h0, cpal_q[cpal_idx]};
    else begin
      case (waddr)
        A_ID:    cur_word = 32'h10;
        A_HD:    cur_word = 32'(width_px[DIM_W-1:2]);
        A_VD:    cur_word = 32'({height_px, 1'b0});
        A_CTL:   cur_word = ctrl_q;
        default: cur_word = '0;
      endcase
    end
  end

  always_comb begin
    new_word = cur_word;
    case (acc_size)
      2'd0: case (acc_addr[1:0])
              2'd0: new_word[7:0]   = acc_wdata[7:0];
              2'd1: new_word[15:8]  = acc_wdata[7:0];
              2'd2: new_word[23:16] = acc_wdata[7:0];
              default: new_word[31:24] = acc_wdata[7:0];
            endcase
      2'd1: if (acc_addr[1]) new_word[31:16] = acc_wdata[15:0];
            else             new_word[15:0]  = acc_wdata[15:0];
      default: new_word = acc_wdata;
    endcase
  end

  always_comb begin
    case (acc_size)
      2'd0: case (acc_addr[1:0])
              2'd0: acc_rdata = {24'h0, cur_word[7:0]};
              2'd1: acc_rdata = {24'h0, cur_word[15:8]};
              2'd2: acc_rdata = {24'h0, cur_word[23:16]};
              default: acc_rdata = {24'h0, cur_word[31:24]};
            endcase
      2'd1: acc_rdata = acc_addr[1] ? {16'h0, cur_word[31:16]} : {16'h0, cur_word[15:0]};
      default: acc_rdata = cur_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_px <= '0; height_px <= '0; ctrl_q <= '0; top_q <= '0; cpos_q <= '0;
    end else if (clr_all) begin
      width_px <= '0; height_px <= '0; ctrl_q <= '0; top_q <= '0; cpos_q <= '0;
    end else if (wr_now) begin
      case (waddr)
        A_HD:    width_px  <= {new_word[DIM_W-3:0], 2'b00};
        A_VD:    height_px <= new_word[DIM_W:1];
        A_CTL:   ctrl_q    <= new_word;
        A_TOP:   top_q     <= new_word;
        A_CPOS:  cpos_q    <= new_word[23:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_ENTRIES; i++) clr_q[i] <= '0;
      for (int i = 0; i < CPAL_N; i++) cpal_q[i] <= '0;
      for (int i = 0; i < CPAT_ENTRIES; i++) cpat_q[i] <= '0;
    end else if (clr_all) begin
      for (int i = 0; i < PAL_ENTRIES; i++) clr_q[i] <= '0;
      for (int i = 0; i < CPAL_N; i++) cpal_q[i] <= '0;
      for (int i = 0; i < CPAT_ENTRIES; i++) cpat_q[i] <= '0;
    end else if (wr_now) begin
      if (in_clr)  clr_q[clr_idx]   <= new_word[23:0];
      if (in_cpal) cpal_q[cpal_idx] <= new_word[23:0];
      if (in_cpat) cpat_q[cpat_idx] <= new_word[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
      bad_write <= 1'b0;
    end else begin
      bad_write <= wr_now && !is_reg && !in_ign && !in_cpal && !in_clr && !in_cpat;
      if (wr_now)            irq <= 1'b0;
      else if (refresh_done) irq <= 1'b1;
    end
  end

  always_comb begin
    case (ctrl_q[22:20])
      3'd0: pixel_depth = 5'd1;
      3'd1: pixel_depth = 5'd2;
      3'd2: pixel_depth = 5'd4;
      3'd3: pixel_depth = 5'd8;
      3'd4: pixel_depth = 5'd15;
      3'd5: pixel_depth = 5'd16;
      default: pixel_depth = 5'd0;
    endcase
  end

  assign force_blank = ctrl_q[10];
  assign cursor_off  = ctrl_q[23];
  assign top_addr    = top_q;
  assign cursor_x    = cpos_q[23:12];
  assign cursor_y    = cpos_q[11:0];
  assign lut_rgb     = clr_q[lut_index];

  p_id_reads_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'd2 && acc_addr == A_ID) |-> acc_rdata == 32'h10);
  p_height_halves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && acc_size == 2'd2 && waddr == A_VD) |=> height_px == $past(acc_wdata[DIM_W:1]));
  p_depth_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pixel_depth) <= 1 || pixel_depth == 5'd15));
  p_bad_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_write |-> $past(acc_en && acc_wr));
  p_write_drops_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> !irq);
  p_refresh_raises_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_done && !wr_now) |=> irq);
  p_soft_reset_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (width_px == '0 && height_px == '0 && ctrl_q == '0 && top_addr == '0 && !irq));

endmodule

// File: tb/tb_disp_ctrl_regs.sv
module tb_disp_ctrl_regs;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0, refresh_done = 0;
  logic [12:0] acc_addr = '0;
  logic [1:0] acc_size = 2'd2;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic [7:0] lut_index = '0;
  logic [23:0] lut_rgb;
  logic [11:0] width_px, height_px, cursor_x, cursor_y;
  logic [4:0] pixel_depth;
  logic force_blank, cursor_off, irq, bad_write;
  logic [31:0] top_addr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  disp_ctrl_regs dut (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .refresh_done(refresh_done), .lut_index(lut_index), .lut_rgb(lut_rgb),
    .width_px(width_px), .height_px(height_px), .pixel_depth(pixel_depth),
    .force_blank(force_blank), .cursor_off(cursor_off), .top_addr(top_addr),
    .cursor_x(cursor_x), .cursor_y(cursor_y), .irq(irq), .bad_write(bad_write));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = a; acc_size = sz;
    #1 d = acc_rdata;
    acc_en = 0;
  endtask

  task automatic lut(input logic [7:0] i, output logic [23:0] d);
    lut_index = i; #1 d = lut_rgb;
  endtask

  task automatic t_reset_state;
    chk(32'(irq), 0, "R11 irq after reset");
    chk(32'(bad_write), 0, "R10 bad after reset");
    chk(32'(width_px), 0, "R12 width after reset");
    chk(32'(pixel_depth), 1, "R4 depth code 0 after reset");
  endtask

  task automatic t_id;
    logic [31:0] v;
    rd(13'h000, 2, v); chk(v, 32'h10, "R1 id read");
    wr(13'h000, 2, 32'hFFFF_FFFF); chk(32'(bad_write), 0, "R1 id write no error");
    rd(13'h000, 2, v); chk(v, 32'h10, "R1 id after write");
    rd(13'h001, 0, v); chk(v, 32'h0, "R6 id byte lane1");
  endtask

  task automatic t_dims;
    logic [31:0] v;
    wr(13'h008, 2, 32'h140); chk(32'(width_px), 1280, "R2 width scaled");
    rd(13'h008, 2, v); chk(v, 32'h140, "R2 width readback");
    wr(13'h010, 2, 32'h3C1); chk(32'(height_px), 480, "R3 height halved");
    rd(13'h010, 2, v); chk(v, 32'h3C0, "R3 height readback odd");
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    logic [4:0] tbl [8] = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16, 5'd0, 5'd0};
    for (int c = 0; c < 8; c++) begin
      wr(13'h018, 2, 32'(c) << 20);
      chk(32'(pixel_depth), 32'(tbl[c]), $sformatf("R4 depth code %0d", c));
    end
    wr(13'h018, 2, 32'h0080_0000);
    chk(32'(cursor_off), 1, "R4 cursor_off bit23");
    wr(13'h018, 2, 32'h0030_0400);
    chk(32'(force_blank), 1, "R4 force_blank bit10");
    chk(32'(cursor_off), 0, "R4 cursor_off clear");
    rd(13'h018, 2, v); chk(v, 32'h0030_0400, "R4 ctrl readback");
  endtask

  task automatic t_narrow_read;
    logic [31:0] v;
    rd(13'h01A, 1, v); chk(v, 32'h0030, "R6 half upper");
    rd(13'h018, 1, v); chk(v, 32'h0400, "R6 half lower");
    rd(13'h01A, 0, v); chk(v, 32'h30, "R6 byte lane2");
    rd(13'h019, 0, v); chk(v, 32'h04, "R6 byte lane1");
  endtask

  task automatic t_tables;
    logic [31:0] v;
    logic [23:0] c;
    wr(13'h828, 2, 32'h00AA_BBCC); lut(5, c); chk(32'(c), 32'hAABBCC, "R5 colour entry 5");
    rd(13'h828, 2, v); chk(v, 0, "R5 colour reads zero");
    wr(13'h82C, 2, 32'h0011_2233); lut(5, c); chk(32'(c), 32'h112233, "R5 slot upper word");
    wr(13'hFF8, 2, 32'h0000_0F0F); lut(255, c); chk(32'(c), 32'h000F0F, "R5 last colour entry");
    wr(13'h110, 2, 32'h0012_3456); rd(13'h110, 2, v); chk(v, 32'h0012_3456, "R5 cursor colour 2");
    rd(13'h100, 2, v); chk(v, 0, "R5 cursor colour 0 untouched");
    wr(13'h1FF8, 2, 32'hDEAD_BEEF); rd(13'h1FF8, 2, v); chk(v, 32'hBEEF, "R5 bitmap last entry");
    rd(13'h1FF0, 2, v); chk(v, 0, "R5 bitmap neighbour");
  endtask

  task automatic t_narrow_write;
    logic [31:0] v;
    logic [23:0] c;
    wr(13'h01B, 0, 32'h55); rd(13'h018, 2, v); chk(v, 32'h5530_0400, "R7 byte merge ctrl");
    chk(32'(pixel_depth), 8, "R7 depth after byte merge");
    wr(13'h01A, 1, 32'h0050); rd(13'h018, 2, v); chk(v, 32'h0050_0400, "R7 half merge ctrl");
    chk(32'(pixel_depth), 16, "R7 depth after half merge");
    wr(13'h021, 0, 32'hAB); chk(top_addr, 32'h0000_AB00, "R7 top byte lane1");
    wr(13'h020, 0, 32'hCD); chk(top_addr, 32'h0000_00CD, "R7 write-only merges zero");
    wr(13'h82A, 0, 32'h77); lut(5, c); chk(32'(c), 32'h770000, "R7 colour byte merge zero");
    wr(13'h1FFA, 1, 32'h1234); rd(13'h1FF8, 2, v); chk(v, 32'hBEEF, "R7 bitmap upper half dropped");
  endtask

  task automatic t_cursor_top;
    logic [31:0] v;
    wr(13'h028, 2, 32'h0012_3045);
    chk(32'(cursor_x), 32'h123, "R8 cursor x");
    chk(32'(cursor_y), 32'h045, "R8 cursor y");
    rd(13'h028, 2, v); chk(v, 0, "R8 cursor reads zero");
    wr(13'h020, 2, 32'h8000_1000); chk(top_addr, 32'h8000_1000, "R8 top word");
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(13'h040, 2, 32'hFFFF_FFFF); chk(32'(bad_write), 0, "R9 ignored low no error");
    wr(13'h07C, 2, 32'hFFFF_FFFF); chk(32'(bad_write), 0, "R9 ignored high no error");
    rd(13'h008, 2, v); chk(v, 32'h140, "R9 width untouched");
    rd(13'h018, 2, v); chk(v, 32'h0050_0400, "R9 ctrl untouched");
    rd(13'h200, 2, v); chk(v, 0, "R9 unmapped read zero");
    wr(13'h200, 2, 32'h1); chk(32'(bad_write), 1, "R10 unmapped write pulse");
    @(negedge clk); chk(32'(bad_write), 0, "R10 pulse one cycle");
    wr(13'h00C, 2, 32'h1); chk(32'(bad_write), 1, "R10 reg+4 unmapped");
    rd(13'h008, 2, v); chk(v, 32'h140, "R10 width untouched");
  endtask

  task automatic t_irq;
    @(negedge clk); refresh_done = 1;
    @(negedge clk); refresh_done = 0;
    chk(32'(irq), 1, "R11 refresh raises");
    @(negedge clk); chk(32'(irq), 1, "R11 irq holds");
    wr(13'h040, 2, 0); chk(32'(irq), 0, "R11 write lowers");
    @(negedge clk); refresh_done = 1;
    @(negedge clk); refresh_done = 0;
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = 13'h040; acc_size = 2; refresh_done = 1;
    @(negedge clk);
    acc_en = 0; acc_wr = 0; refresh_done = 0;
    chk(32'(irq), 0, "R11 write wins over refresh");
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    logic [23:0] c;
    @(negedge clk); refresh_done = 1;
    @(negedge clk); refresh_done = 0;
    wr(13'h030, 2, 32'h0);
    chk(32'(irq), 0, "R12 irq cleared");
    chk(32'(width_px), 0, "R12 width cleared");
    chk(32'(height_px), 0, "R12 height cleared");
    chk(32'(pixel_depth), 1, "R12 depth back to code 0");
    chk(top_addr, 0, "R12 top cleared");
    chk(32'(cursor_x), 0, "R12 cursor cleared");
    rd(13'h018, 2, v); chk(v, 0, "R12 ctrl cleared");
    rd(13'h110, 2, v); chk(v, 0, "R12 cursor colour cleared");
    rd(13'h1FF8, 2, v); chk(v, 0, "R12 bitmap cleared");
    lut(255, c); chk(32'(c), 0, "R12 colour table cleared");
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state;
    t_id;
    t_dims;
    t_ctrl;
    t_narrow_read;
    t_tables;
    t_narrow_write;
    t_cursor_top;
    t_unmapped;
    t_irq;
    t_soft_reset;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule